// File: doc/BRIEF.md
# Multi-Source Stream Packetizer with CRC-12

This block gathers frames from several independent device sources and places them, one whole packet at a time, onto a 12-bit parallel bus that feeds a camera-style serializer input. Two strobes qualify the bus. The line-sync strobe marks the word that carries the device index. The frame-sync strobe marks the trailing check word. Between those two words the bus carries the frame words of the granted source, one word per clock.

Each source first offers a packet header, made of a device index and a frame length, through a valid/ready handshake. A round-robin arbiter picks one requesting source and captures its header. After that, the block pulls that source's frame words on consecutive clocks using a per-source take pulse. It then appends a CRC-12 computed over the index word and every frame word. No other source can reach the bus until that check word has been sent. A later packet may start on the clock right after the check word.

Top module: `pkt_stream_arb`

## Requirements
- R1: Outside a packet, both strobes are low and the data bus is zero.
- R2: A packet appears as the index word with `ser_hsync`=1, then exactly the captured number of frame words with both strobes low, then the check word with `ser_vsync`=1. The two strobes are never high together.
- R3: The check word is the CRC-12 with polynomial x^12+x^11+x^3+x^2+x+1 (0x80F). It is seeded with zero, is not reflected, and has no output XOR. It takes the index word and then each frame word, 12 bits per step, most significant bit first.
- R4: Arbitration is round-robin. Source 0 has first priority after reset. After a grant to source k, the search starts at source k+1, wrapping from N_SRC-1 to 0. A source is granted only while its `src_valid` bit is high.
- R5: Once a source is granted, its packet goes out as one unbroken run, one word per clock, and no word of another source is interleaved.
- R6: The length is captured at the grant. Later changes of `src_len` have no effect on that packet. A length of 0 gives the index word followed directly by the check word. A length above MAX_LEN is treated as MAX_LEN.
- R7: In the arbitration cycle, `src_hdr_ready` pulses for one clock for the winner only. The index word appears on the bus in the next cycle. `src_word_take` is high for the granted source in each cycle where `src_word` is consumed. The word consumed in that cycle appears on the bus in the following cycle, in the order taken.
- R8: When another source is waiting, its index word follows the previous check word on the very next clock.
- R9: A synchronous active-high reset clears the strobes and the bus on the next clock, abandons a packet in progress, and returns the arbitration priority to source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all words launch on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | N_SRC | Per-source request: header on src_index/src_len is offered |
| src_hdr_ready | output | N_SRC | One-clock header acceptance for the arbitration winner |
| src_index | input | N_SRC*12 | Per-source device index word |
| src_len | input | N_SRC*LEN_W | Per-source frame length in words |
| src_word | input | N_SRC*12 | Per-source current frame word |
| src_word_take | output | N_SRC | Per-source pulse: current frame word consumed this cycle |
| ser_data | output | 12 | Registered serializer data bus |
| ser_hsync | output | 1 | High while ser_data carries the index word |
| ser_vsync | output | 1 | High while ser_data carries the check word |

## Verification
The bench builds the block with four sources and MAX_LEN of 8, which makes LEN_W four bits wide. This lets a length input of 15 test the clamp and keeps every packet short. With four sources, a single burst in which all of them request at once walks the round-robin pointer across its wrap point. Pairs of requests placed after that burst show the search restarting past the last winner. The short frames also let one run cover back-to-back packets, a zero-length packet, a length change after the grant and a reset in mid-packet.

// File: rtl/pkt_stream_pkg.sv
package pkt_stream_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_BODY = 2'd1,
    PS_TAIL = 2'd2
  } pkt_state_e;
endpackage

// File: rtl/pkt_crc12.sv
// One parallel CRC step: folds a whole data word into the running remainder.
module pkt_crc12 #(
  parameter int          W    = 12,
  parameter logic [W-1:0] POLY = 'h80F
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  always_comb begin
    logic [W-1:0] c;
    logic         fb;
    c = crc_i;
    for (int i = W - 1; i >= 0; i--) begin
      fb = c[W-1] ^ data_i[i];
      c  = {c[W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/pkt_lane_mux.sv
// Selects one lane from a flattened per-source bus.
module pkt_lane_mux #(
  parameter int N  = 4,
  parameter int W  = 12,
  parameter int SW = 2
) (
  input  logic [N*W-1:0] lanes_i,
  input  logic [SW-1:0]  sel_i,
  output logic [W-1:0]   lane_o
);
  logic [W-1:0] lane_a [N];
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane_a[g] = lanes_i[g*W +: W];
  end
  assign lane_o = lane_a[sel_i];
endmodule

// File: rtl/pkt_rr_arbiter.sv
// Round-robin pick among requesters; pointer moves past the winner on advance.
module pkt_rr_arbiter #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW:0]   N_L  = (IW+1)'(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q;

  always_comb begin
    logic [IW:0] cand;
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      cand = {1'b0, ptr_q} + (IW+1)'(k);
      if (cand >= N_L) cand = cand - N_L;
      if (!any_o && req_i[cand[IW-1:0]]) begin
        any_o = 1'b1;
        idx_o = cand[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv_i && any_o) begin
      ptr_q <= (idx_o == LAST) ? '0 : idx_o + 1'b1;
    end
  end

  // R4: the winner is always a current requester
  p_pick_requested_r4: assert property (@(posedge clk) disable iff (rst)
    any_o |-> req_i[idx_o]);
  // R4: search start stays inside the source range
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);
endmodule

// File: rtl/pkt_stream_arb.sv
module pkt_stream_arb
  import pkt_stream_pkg::*;
#(
  parameter int N_SRC   = 4,
  parameter int WORD_W  = 12,
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        src_valid,
  output logic [N_SRC-1:0]        src_hdr_ready,
  input  logic [N_SRC*WORD_W-1:0] src_index,
  input  logic [N_SRC*LEN_W-1:0]  src_len,
  input  logic [N_SRC*WORD_W-1:0] src_word,
  output logic [N_SRC-1:0]        src_word_take,
  output logic [WORD_W-1:0]       ser_data,
  output logic                    ser_hsync,
  output logic                    ser_vsync
);
  localparam int               IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  pkt_state_e        state_q;
  logic [IW-1:0]     gnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [WORD_W-1:0] crc_q;

  logic              arb_any;
  logic [IW-1:0]     arb_idx;
  logic [WORD_W-1:0] idx_sel;
  logic [WORD_W-1:0] word_sel;
  logic [LEN_W-1:0]  len_sel;
  logic [LEN_W-1:0]  len_clamp;
  logic [WORD_W-1:0] crc_seed;
  logic [WORD_W-1:0] crc_data;
  logic [WORD_W-1:0] crc_next;
  logic [LEN_W-1:0]  cnt_next;
  logic              in_idle;

  assign in_idle = (state_q == PS_IDLE);

  pkt_rr_arbiter #(.N(N_SRC), .IW(IW)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req_i (src_valid),
    .adv_i (in_idle),
    .any_o (arb_any),
    .idx_o (arb_idx)
  );

  pkt_lane_mux #(.N(N_SRC), .W(WORD_W), .SW(IW)) u_idx_mux (
    .lanes_i (src_index), .sel_i (arb_idx), .lane_o (idx_sel));
  pkt_lane_mux #(.N(N_SRC), .W(LEN_W), .SW(IW)) u_len_mux (
    .lanes_i (src_len), .sel_i (arb_idx), .lane_o (len_sel));
  pkt_lane_mux #(.N(N_SRC), .W(WORD_W), .SW(IW)) u_word_mux (
    .lanes_i (src_word), .sel_i (gnt_q), .lane_o (word_sel));

  assign len_clamp = (len_sel > MAX_L) ? MAX_L : len_sel;
  assign crc_seed  = in_idle ? '0 : crc_q;
  assign crc_data  = in_idle ? idx_sel : word_sel;
  assign cnt_next  = cnt_q + 1'b1;

  pkt_crc12 #(.W(WORD_W)) u_crc (
    .crc_i (crc_seed), .data_i (crc_data), .crc_o (crc_next));

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      src_hdr_ready[i] = in_idle && arb_any && (arb_idx == IW'(i));
      src_word_take[i] = (state_q == PS_BODY) && (gnt_q == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PS_IDLE;
      gnt_q     <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      crc_q     <= '0;
      ser_data  <= '0;
      ser_hsync <= 1'b0;
      ser_vsync <= 1'b0;
    end else begin
      ser_hsync <= 1'b0;
      ser_vsync <= 1'b0;
      unique case (state_q)
        PS_IDLE: begin
          if (arb_any) begin
            ser_data  <= idx_sel;
            ser_hsync <= 1'b1;
            crc_q     <= crc_next;
            gnt_q     <= arb_idx;
            len_q     <= len_clamp;
            cnt_q     <= '0;
            state_q   <= (len_clamp == '0) ? PS_TAIL : PS_BODY;
          end else begin
            ser_data <= '0;
          end
        end
        PS_BODY: begin
          ser_data <= word_sel;
          crc_q    <= crc_next;
          cnt_q    <= cnt_next;
          if (cnt_next == len_q) state_q <= PS_TAIL;
        end
        PS_TAIL: begin
          ser_data  <= crc_q;
          ser_vsync <= 1'b1;
          state_q   <= PS_IDLE;
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  // R2: strobes are mutually exclusive
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(ser_hsync && ser_vsync));
  // R2: an index word never repeats on the next clock
  p_hsync_single_r2: assert property (@(posedge clk) disable iff (rst)
    ser_hsync |=> !ser_hsync);
  // R2: the tail state always launches the check word
  p_tail_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_TAIL) |=> ser_vsync);
  // R7: at most one header accepted, only from a requester
  p_hdr_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_hdr_ready) && ((src_hdr_ready & ~src_valid) == '0));
  // R5: words are pulled from a single source only
  p_take_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_word_take));
  // R5: no new header while frame words are being pulled
  p_no_hdr_in_body_r5: assert property (@(posedge clk) disable iff (rst)
    (|src_word_take) |-> (src_hdr_ready == '0));
  // R6: captured length honours the cap and the count never passes it
  p_len_cap_r6: assert property (@(posedge clk) disable iff (rst)
    (len_q <= MAX_L) && (cnt_q <= len_q));
endmodule

// File: tb/pkt_stream_arb_bench.sv
`timescale 1ns/1ps
module pkt_stream_arb_bench;
  localparam int N    = 4;
  localparam int W    = 12;
  localparam int MAXL = 8;
  localparam int LW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]    src_valid;
  logic [N-1:0]    src_hdr_ready;
  logic [N*W-1:0]  src_index;
  logic [N*LW-1:0] src_len;
  logic [N*W-1:0]  src_word;
  logic [N-1:0]    src_word_take;
  logic [W-1:0]    ser_data;
  logic            ser_hsync;
  logic            ser_vsync;

  pkt_stream_arb #(.N_SRC(N), .WORD_W(W), .MAX_LEN(MAXL), .LEN_W(LW)) u_pkt_stream_arb (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_hdr_ready(src_hdr_ready),
    .src_index(src_index), .src_len(src_len), .src_word(src_word),
    .src_word_take(src_word_take), .ser_data(ser_data),
    .ser_hsync(ser_hsync), .ser_vsync(ser_vsync));

  int n_chk = 0;
  int n_bad = 0;

  // source models
  bit   v_valid [N];
  int   len_in  [N];
  int   seed_src[N];
  int   ptr     [N];
  bit   hdr_q   [N];
  bit   pop_q   [N];
  int   exp_len [N];
  int   exp_seed[N];

  function automatic logic [W-1:0] gen(int sd, int pos);
    return W'((sd * 53 + pos * 157 + pos * pos * 7) ^ (sd << 4));
  endfunction

  function automatic logic [W-1:0] id_of(int s);
    return W'(12'h5A0 + s);
  endfunction

  function automatic logic [W-1:0] crc_ref(logic [W-1:0] c, logic [W-1:0] d);
    logic [W-1:0] r;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      if (r[W-1] ^ d[i]) r = {r[W-2:0], 1'b0} ^ 12'h80F;
      else               r = {r[W-2:0], 1'b0};
    end
    return r;
  endfunction

  always_comb begin
    for (int s = 0; s < N; s++) begin
      src_valid[s]             = v_valid[s];
      src_index[s*W +: W]      = id_of(s);
      src_len[s*LW +: LW]      = LW'(len_in[s]);
      src_word[s*W +: W]       = gen(seed_src[s], ptr[s]);
    end
  end

  always @(negedge clk) begin
    for (int s = 0; s < N; s++) begin
      hdr_q[s] = src_hdr_ready[s];
      pop_q[s] = src_word_take[s];
    end
  end

  always @(posedge clk) begin
    #1;
    for (int s = 0; s < N; s++) begin
      if (hdr_q[s]) begin v_valid[s] = 1'b0; ptr[s] = 0; end
      if (pop_q[s]) ptr[s] = ptr[s] + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  int           cyc = 0;
  bit           in_pkt = 1'b0;
  int           cur_src = 0;
  int           nw = 0;
  bit           words_ok = 1'b1;
  logic [W-1:0] crc_acc = '0;
  int           last_v = -100;
  int           pkt_count = 0;
  int           log_src[64];
  int           log_gap[64];
  int           gap_cur = 0;
  bit           prev_hdr[N];

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      in_pkt = 1'b0;
    end else begin
      chk(!(ser_hsync && ser_vsync), "R2 strobes both high", {ser_hsync, ser_vsync}, 0);
      if (ser_hsync) begin
        chk(!in_pkt, "R5 index word inside another packet", in_pkt, 0);
        cur_src = int'(ser_data) - 12'h5A0;
        chk(cur_src >= 0 && cur_src < N, "R2 index word value", ser_data, 12'h5A0);
        if (cur_src < 0 || cur_src >= N) cur_src = 0;
        chk(prev_hdr[cur_src], "R7 index word one clock after header accept", 0, 1);
        gap_cur = cyc - last_v - 1;
        in_pkt = 1'b1; nw = 0; words_ok = 1'b1;
        crc_acc = crc_ref('0, ser_data);
      end else if (ser_vsync) begin
        chk(in_pkt, "R2 check word outside packet", in_pkt, 1);
        chk(ser_data == crc_acc, "R3 check word", ser_data, crc_acc);
        chk(nw == exp_len[cur_src], "R6 frame word count", nw, exp_len[cur_src]);
        chk(words_ok, "R5 frame words in order", words_ok, 1);
        if (pkt_count < 64) begin
          log_src[pkt_count] = cur_src;
          log_gap[pkt_count] = gap_cur;
        end
        pkt_count++;
        in_pkt = 1'b0;
        last_v = cyc;
      end else if (in_pkt) begin
        if (ser_data != gen(exp_seed[cur_src], nw)) words_ok = 1'b0;
        crc_acc = crc_ref(crc_acc, ser_data);
        nw++;
      end else begin
        chk(ser_data == '0, "R1 idle bus zero", ser_data, 0);
      end
    end
    for (int s = 0; s < N; s++) prev_hdr[s] = src_hdr_ready[s];
  end

  task automatic arm(int s, int len, int sd);
    len_in[s]   = len;
    seed_src[s] = sd;
    exp_seed[s] = sd;
    exp_len[s]  = (len > MAXL) ? MAXL : len;
    v_valid[s]  = 1'b1;
  endtask

  task automatic wait_pkts(int target);
    while (pkt_count < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_idle();
    repeat (4) @(negedge clk);
    chk(ser_data == '0 && !ser_hsync && !ser_vsync, "R9 outputs clear after reset",
        {ser_hsync, ser_vsync, ser_data}, 0);
  endtask

  task automatic t_single();
    int b = pkt_count;
    @(posedge clk); #2; arm(1, 5, 7);
    wait_pkts(b + 1);
    chk(log_src[b] == 1, "R2 single packet source", log_src[b], 1);
  endtask

  task automatic t_zero_len();
    int b = pkt_count;
    @(posedge clk); #2; arm(2, 0, 3);
    wait_pkts(b + 1);
    chk(log_src[b] == 2, "R6 zero length packet sent", log_src[b], 2);
  endtask

  task automatic t_clamp();
    int b = pkt_count;
    @(posedge clk); #2; arm(3, 15, 11);
    wait_pkts(b + 1);
    chk(log_src[b] == 3, "R6 clamped packet sent", log_src[b], 3);
  endtask

  task automatic t_len_hold();
    int b = pkt_count;
    @(posedge clk); #2; arm(0, 3, 21);
    while (v_valid[0]) @(negedge clk);
    @(posedge clk); #2; len_in[0] = 7;
    wait_pkts(b + 1);
    chk(log_src[b] == 0, "R6 length held after grant", log_src[b], 0);
  endtask

  task automatic t_reset_mid();
    @(posedge clk); #2; arm(1, 8, 5);
    repeat (4) @(posedge clk);
    #2; rst = 1'b1;
    for (int s = 0; s < N; s++) begin v_valid[s] = 1'b0; ptr[s] = 0; end
    @(posedge clk);
    @(negedge clk);
    chk(ser_data == '0 && !ser_hsync && !ser_vsync, "R9 reset clears mid packet",
        {ser_hsync, ser_vsync, ser_data}, 0);
    @(posedge clk); #2; rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_rr_all();
    int b = pkt_count;
    @(posedge clk); #2;
    arm(0, 2, 31); arm(1, 3, 32); arm(2, 1, 33); arm(3, 4, 34);
    wait_pkts(b + 4);
    for (int k = 0; k < 4; k++)
      chk(log_src[b+k] == k, "R4 R9 round-robin order from source 0", log_src[b+k], k);
    for (int k = 1; k < 4; k++)
      chk(log_gap[b+k] == 0, "R8 back-to-back gap", log_gap[b+k], 0);
  endtask

  task automatic t_rr_pair(int a, int c, int first, int second);
    int b = pkt_count;
    @(posedge clk); #2;
    arm(a, 2, 40 + a); arm(c, 3, 50 + c);
    wait_pkts(b + 2);
    chk(log_src[b] == first,  "R4 rotation first winner", log_src[b], first);
    chk(log_src[b+1] == second, "R4 rotation second winner", log_src[b+1], second);
    chk(log_gap[b+1] == 0, "R8 back-to-back gap", log_gap[b+1], 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin
      v_valid[s] = 1'b0; len_in[s] = 0; seed_src[s] = 0; ptr[s] = 0;
      exp_len[s] = 0; exp_seed[s] = 0; hdr_q[s] = 1'b0; pop_q[s] = 1'b0;
      prev_hdr[s] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
    t_idle();
    t_single();
    t_zero_len();
    t_clamp();
    t_len_hold();
    t_reset_mid();
    t_rr_all();
    t_rr_pair(0, 2, 0, 2);
    t_rr_pair(1, 3, 3, 1);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", pkt_count, 0);
    finish_run();
  end
endmodule